// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a small processor core. It holds a 42-bit signed running sum, kept as a 32-bit low word and a 10-bit high extension. On a single-cycle command strobe it does one of four things: it adds the signed product of two 16-bit operands to the sum, it clears the sum, or it loads the low word or the high extension from a 32-bit value. The operands arrive already fetched. Register-file access and address stepping belong to the surrounding core.

Either part of the sum can be read at any time on a combinational 32-bit read port. The high extension is sign-extended to 32 bits when read. Three status flags travel with every read: zero, negative and overflow. Zero and negative describe the whole 42-bit sum, not only the part being read. Overflow always reads clear, because the sum wraps rather than saturates.

The state of the block is the sum register. Its command decoder resolves each strobe into one of five named actions: IDLE, CLEAR, LOAD_LO, LOAD_HI and ACCUM. Every action returns to IDLE on the next edge unless another strobe arrives. IDLE holds the sum, CLEAR zeroes it, LOAD_LO and LOAD_HI replace one part, and ACCUM adds the product.

Top module: `smac_unit`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) both parts of the sum read as zero, and the zero flag is set.
- R2: A strobe with `cmd_code` = 4 (accumulate) adds the product of `op_a` and `op_b` to the sum at that clock edge. Both operands are taken as signed two's-complement values.
- R3: The sum is 42 bits wide and wraps modulo 2^42. Totals beyond 32 bits carry into the high extension: eight products of 0x7FFF by 0x7FFF read back as low 0xFFF80008 and high 1.
- R4: `cmd_code` = 2 (load low) copies `load_data` into the low word and leaves the high extension unchanged.
- R5: `cmd_code` = 3 (load high) keeps only bits 9:0 of `load_data` and leaves the low word unchanged. Loading 0xA5A5A5A5 reads back as 0x000001A5.
- R6: With `rd_hi` = 1, `rd_data` returns the high extension sign-extended to 32 bits; with `rd_hi` = 0 it returns the low word. A sum of -4 reads high 0xFFFFFFFF and low 0xFFFFFFFC.
- R7: `cmd_code` = 1 (clear) zeroes both parts.
- R8: `flag_z` is set only when all 42 bits of the sum are zero, whichever part is being read.
- R9: `flag_n` equals bit 41 of the sum, whichever part is being read.
- R10: `flag_v` always reads clear.
- R11: The sum does not change when `cmd_valid` is low, nor when it is high with `cmd_code` 0, 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_code | input | 3 | Command: 1 clear, 2 load low, 3 load high, 4 accumulate |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| load_data | input | 32 | Value for the load commands |
| rd_hi | input | 1 | Read select: 1 high extension, 0 low word |
| rd_data | output | 32 | Selected part of the sum |
| flag_z | output | 1 | Whole sum is zero |
| flag_n | output | 1 | Whole sum is negative |
| flag_v | output | 1 | Overflow, always clear |

## Verification
Accumulation is tried with several operand patterns:
- Small positive operands (2 by 2) leave the high extension zero while the zero flag stays clear. This separates a whole-sum zero test from a test of only the part being read.
- A zero product shows that the zero flag sets.
- A negative by positive product shows sign extension into the high part and the negative flag on both reads.
- A run of maximum positive products carries past bit 31.
- A load that puts the sum just below 2^42 exposes the wrap.
- Several hundred seeded random commands are compared against a 42-bit model computed in the bench. This covers mixed signs, extreme operands, interleaved loads and clears, and ignored codes.

// File: rtl/smac_pkg.sv
package smac_pkg;
    typedef enum logic [2:0] {
        ACT_IDLE    = 3'd0,
        ACT_CLEAR   = 3'd1,
        ACT_LOAD_LO = 3'd2,
        ACT_LOAD_HI = 3'd3,
        ACT_ACCUM   = 3'd4
    } smac_act_e;
endpackage

// File: rtl/smac_decode.sv
module smac_decode
    import smac_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    output smac_act_e  act
);
    always_comb begin
        act = ACT_IDLE;
        if (cmd_valid) begin
            unique case (cmd_code)
                3'd1:    act = ACT_CLEAR;
                3'd2:    act = ACT_LOAD_LO;
                3'd3:    act = ACT_LOAD_HI;
                3'd4:    act = ACT_ACCUM;
                default: act = ACT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/smac_mult.sv
module smac_mult #(
    parameter int OP_W = 16,
    localparam int PROD_W = 2 * OP_W
) (
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [PROD_W-1:0] prod
);
    logic signed [OP_W-1:0]   sa;
    logic signed [OP_W-1:0]   sb;
    logic signed [PROD_W-1:0] sp;

    always_comb begin
        sa   = signed'(op_a);
        sb   = signed'(op_b);
        sp   = PROD_W'(sa) * PROD_W'(sb);
        prod = unsigned'(sp);
    end
endmodule

// File: rtl/smac_accum.sv
module smac_accum
    import smac_pkg::*;
#(
    parameter int LO_W   = 32,
    parameter int HI_W   = 10,
    parameter int PROD_W = 32,
    localparam int ACC_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  smac_act_e         act,
    input  logic [PROD_W-1:0] prod,
    input  logic [LO_W-1:0]   load_data,
    output logic [ACC_W-1:0]  acc
);
    logic [ACC_W-1:0] acc_nxt;
    logic [ACC_W-1:0] prod_ext;

    assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

    // state register
    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc_nxt;
    end

    // next-state logic
    always_comb begin
        acc_nxt = acc;
        unique case (act)
            ACT_IDLE:    acc_nxt = acc;
            ACT_CLEAR:   acc_nxt = '0;
            ACT_LOAD_LO: acc_nxt = {acc[ACC_W-1:LO_W], load_data};
            ACT_LOAD_HI: acc_nxt = {load_data[HI_W-1:0], acc[LO_W-1:0]};
            ACT_ACCUM:   acc_nxt = acc + prod_ext;
            default:     acc_nxt = acc;
        endcase
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> acc == '0);

    assert_accum_sum_R2: assert property (@(posedge clk) disable iff (rst)
        act == ACT_ACCUM |=> acc == $past(acc) + $past(prod_ext));

    assert_load_lo_R4: assert property (@(posedge clk) disable iff (rst)
        act == ACT_LOAD_LO |=> acc[LO_W-1:0] == $past(load_data)
                               && acc[ACC_W-1:LO_W] == $past(acc[ACC_W-1:LO_W]));

    assert_load_hi_R5: assert property (@(posedge clk) disable iff (rst)
        act == ACT_LOAD_HI |=> acc[ACC_W-1:LO_W] == $past(load_data[HI_W-1:0])
                               && acc[LO_W-1:0] == $past(acc[LO_W-1:0]));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        act == ACT_CLEAR |=> acc == '0);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        act == ACT_IDLE |=> $stable(acc));
endmodule

// File: rtl/smac_readout.sv
module smac_readout #(
    parameter int LO_W = 32,
    parameter int HI_W = 10,
    localparam int ACC_W = LO_W + HI_W
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             rd_hi,
    output logic [LO_W-1:0]  rd_data,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_v
);
    logic [LO_W-1:0] hi_ext;

    assign hi_ext = {{(LO_W-HI_W){acc[ACC_W-1]}}, acc[ACC_W-1:LO_W]};

    always_comb begin
        rd_data = rd_hi ? hi_ext : acc[LO_W-1:0];
        flag_z  = (acc == '0);
        flag_n  = acc[ACC_W-1];
        flag_v  = 1'b0;
    end

    // a zero flag must come with a zero read, whichever part is selected
    always_comb begin
        if (flag_z) assert_zero_read_R8: assert (rd_data == '0);
    end
endmodule

// File: rtl/smac_unit.sv
module smac_unit #(
    parameter int OP_W = 16,
    parameter int LO_W = 32,
    parameter int HI_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_code,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  logic [LO_W-1:0] load_data,
    input  logic            rd_hi,
    output logic [LO_W-1:0] rd_data,
    output logic            flag_z,
    output logic            flag_n,
    output logic            flag_v
);
    import smac_pkg::*;

    localparam int PROD_W = 2 * OP_W;
    localparam int ACC_W  = LO_W + HI_W;

    smac_act_e         act;
    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  acc;

    smac_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .act       (act)
    );

    smac_mult #(.OP_W(OP_W)) u_mult (
        .op_a (op_a),
        .op_b (op_b),
        .prod (prod)
    );

    smac_accum #(.LO_W(LO_W), .HI_W(HI_W), .PROD_W(PROD_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .prod      (prod),
        .load_data (load_data),
        .acc       (acc)
    );

    smac_readout #(.LO_W(LO_W), .HI_W(HI_W)) u_readout (
        .acc     (acc),
        .rd_hi   (rd_hi),
        .rd_data (rd_data),
        .flag_z  (flag_z),
        .flag_n  (flag_n),
        .flag_v  (flag_v)
    );
endmodule

// File: tb/test_smac_unit.sv
`timescale 1ns/1ps
module test_smac_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_code;
    logic [15:0] op_a, op_b;
    logic [31:0] load_data;
    logic        rd_hi;
    logic [31:0] rd_data;
    logic        flag_z, flag_n, flag_v;

    int checks = 0;
    int failures = 0;
    logic [41:0] m_acc;

    always #4 clk = ~clk;

    smac_unit i_smac_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .op_a(op_a), .op_b(op_b), .load_data(load_data), .rd_hi(rd_hi),
        .rd_data(rd_data), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
    );

    function automatic logic [41:0] model_step(logic [41:0] acc, logic [2:0] code,
                                               logic [15:0] a, logic [15:0] b,
                                               logic [31:0] d);
        logic signed [31:0] p;
        p = 32'(signed'(a)) * 32'(signed'(b));
        case (code)
            3'd1:    return '0;
            3'd2:    return {acc[41:32], d};
            3'd3:    return {d[9:0], acc[31:0]};
            3'd4:    return acc + {{10{p[31]}}, p};
            default: return acc;
        endcase
    endfunction

    function automatic logic [31:0] exp_hi(logic [41:0] acc);
        return {{22{acc[41]}}, acc[41:32]};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare both read selections and all flags against the model
    task automatic check_all(string req);
        rd_hi = 1'b0; #1;
        chk(req, "low word", rd_data, m_acc[31:0]);
        chk(req, "zero flag", 32'(flag_z), 32'(m_acc == '0));
        chk(req, "neg flag", 32'(flag_n), 32'(m_acc[41]));
        chk("R10", "ovf flag", 32'(flag_v), 32'd0);
        rd_hi = 1'b1; #1;
        chk(req, "high part", rd_data, exp_hi(m_acc));
        chk(req, "zero flag hi", 32'(flag_z), 32'(m_acc == '0));
        chk(req, "neg flag hi", 32'(flag_n), 32'(m_acc[41]));
        rd_hi = 1'b0;
    endtask

    // drive at the falling edge, the sum updates at the next rising edge
    task automatic issue(logic v, logic [2:0] code, logic [15:0] a, logic [15:0] b,
                         logic [31:0] d);
        @(negedge clk);
        cmd_valid = v; cmd_code = code; op_a = a; op_b = b; load_data = d;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (v) m_acc = model_step(m_acc, code, a, b, d);
    endtask

    task automatic expect_parts(string req, logic [31:0] hi, logic [31:0] lo);
        rd_hi = 1'b0; #1; chk(req, "directed low", rd_data, lo);
        rd_hi = 1'b1; #1; chk(req, "directed high", rd_data, hi);
        rd_hi = 1'b0;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; cmd_valid = 1'b0; cmd_code = '0; op_a = '0; op_b = '0;
        load_data = '0; rd_hi = 1'b0; m_acc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check_all("R1");
        expect_parts("R1", 32'h0, 32'h0);

        // R2, R8: 2*2 leaves high part zero but zero flag clear
        issue(1, 3'd4, 16'd2, 16'd2, '0);
        check_all("R8");
        expect_parts("R2", 32'h0, 32'd4);
        rd_hi = 1'b1; #1; chk("R8", "zero flag on zero high", 32'(flag_z), 32'd0);
        rd_hi = 1'b0;

        // R7 clear, then zero product
        issue(1, 3'd1, '0, '0, '0);
        expect_parts("R7", 32'h0, 32'h0);
        issue(1, 3'd4, 16'd0, 16'd0, '0);
        check_all("R8");

        // R6, R9: -2*2
        issue(1, 3'd4, 16'hFFFE, 16'd2, '0);
        expect_parts("R6", 32'hFFFFFFFF, 32'hFFFFFFFC);
        rd_hi = 1'b1; #1; chk("R9", "neg flag hi", 32'(flag_n), 32'd1);
        rd_hi = 1'b0;

        // R3: eight max products
        issue(1, 3'd1, '0, '0, '0);
        for (int i = 0; i < 8; i++) issue(1, 3'd4, 16'h7FFF, 16'h7FFF, '0);
        expect_parts("R3", 32'd1, 32'hFFF80008);
        check_all("R3");

        // R4, R5: loads
        issue(1, 3'd2, '0, '0, 32'hA5A5A5A5);
        expect_parts("R4", 32'd1, 32'hA5A5A5A5);
        issue(1, 3'd3, '0, '0, 32'hA5A5A5A5);
        expect_parts("R5", 32'h000001A5, 32'hA5A5A5A5);
        issue(1, 3'd3, '0, '0, 32'h00000200);
        expect_parts("R6", 32'hFFFFFE00, 32'hA5A5A5A5);

        // R3 wrap: all ones plus 1 gives zero
        issue(1, 3'd3, '0, '0, 32'h3FF);
        issue(1, 3'd2, '0, '0, 32'hFFFFFFFF);
        issue(1, 3'd4, 16'd1, 16'd1, '0);
        expect_parts("R3", 32'h0, 32'h0);
        check_all("R3");

        // R11: ignored strobes
        issue(1, 3'd2, '0, '0, 32'h12345678);
        issue(0, 3'd4, 16'h7FFF, 16'h7FFF, 32'hFFFFFFFF);
        expect_parts("R11", 32'h0, 32'h12345678);
        for (int c = 5; c < 8; c++) issue(1, 3'(c), 16'h1234, 16'h4321, 32'hFFFFFFFF);
        issue(1, 3'd0, 16'h1234, 16'h4321, 32'hFFFFFFFF);
        expect_parts("R11", 32'h0, 32'h12345678);

        // random mix checked against the model
        for (int n = 0; n < 400; n++) begin
            logic [2:0]  rc;
            logic [15:0] ra, rb;
            int sel;
            sel = $urandom_range(0, 19);
            rc = (sel < 12) ? 3'd4 : (sel < 14) ? 3'd2 : (sel < 16) ? 3'd3 :
                 (sel < 17) ? 3'd1 : 3'($urandom_range(0, 7));
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (sel == 19) begin ra = 16'h8000; rb = 16'h8000; end
            issue(($urandom_range(0, 9) != 0), rc, ra, rb, $urandom);
            check_all("R2");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule